// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous 4M x 4 DRAM alive. After reset it waits out the power-up pause. It then runs a burst of CAS-before-RAS refresh cycles to initialise the device, and only after that does it raise `ready`. From then on an interval timer adds one owed refresh to a small backlog counter at a fixed period. The period is sized so that 4096 refreshes spread evenly over 64 ms, which is about 15.6 µs or 1562 cycles at 100 MHz.

Whenever the device still needs initialisation cycles, or the backlog is not empty, the block raises `refresh_req` toward the access sequencer. After `refresh_grant` arrives, it drives the strobes itself: CAS low first, then RAS low, then both high for the precharge time. The device's own row counter supplies the row, so no address, data or output-enable pin is involved. `refresh_req` drops once the precharge is over, and the sequencer returns the grant after that.

The block watches for two fault conditions:
- **Backlog overflow.** If the sequencer holds the bus so long that the backlog overflows, a sticky error flag is set.
- **Starvation.** If no refresh completes for the whole stale limit (8 ms by default), the device must be treated as uninitialised. `ready` falls and the full initialisation burst runs again.

The sequencer FSM has six states:

| State | Role |
|---|---|
| PWRUP | Power-up pause |
| IDLE | Waits for work and a grant |
| CAS_LEAD | CAS low, RAS high |
| RAS_LOW | Both strobes low |
| PRECH | Both strobes high; request still held |
| RELEASE | Request dropped; waits for the grant to go low |

Its transitions are:
- PWRUP to IDLE when the pause count ends.
- IDLE to CAS_LEAD when work is pending, a grant is present and no starvation is flagged.
- IDLE to IDLE, with a re-initialisation, when starvation is flagged.
- CAS_LEAD to RAS_LOW, RAS_LOW to PRECH and PRECH to RELEASE, each when its phase count ends.
- RELEASE to IDLE once the grant is low.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `refresh_req` stays low and both strobes stay high for the first PWRUP_CYC clock edges. `refresh_req` is high after edge PWRUP_CYC.
- R2: `ready` is low from reset until INIT_CYCLES CAS-before-RAS cycles have completed. It rises on the same edge that ends the RAS-low phase of the last of those cycles.
- R3: In each refresh cycle, `cas_n` is low (active low) for exactly CAS_LEAD_CYC cycles with `ras_n` high before `ras_n` falls. `ras_n` is never low while `cas_n` is high. Both strobes rise on the same edge.
- R4: `ras_n` stays low for exactly RAS_LOW_CYC cycles. `ras_n` stays high for at least RAS_PRE_CYC cycles between two refresh cycles.
- R5: A refresh cycle starts (CAS falls) only on an edge where `refresh_grant` is high. `refresh_req` stays high until exactly RAS_PRE_CYC cycles after RAS rises. No further cycle starts until the grant has been low for at least one edge.
- R6: After `ready` rises, one refresh is owed every REF_INTERVAL cycles. Whenever the request and grant are both quiet, the number of refreshes completed since `ready` rose equals the number of intervals that have elapsed.
- R7: Up to PEND_MAX owed refreshes are held while the grant is withheld. The next owed refresh beyond that sets `overflow_err`, which then stays set until reset.
- R8: If no refresh completes for STALE_LIMIT cycles while `ready` is high, `ready` falls. A fresh burst of INIT_CYCLES cycles must then run before `ready` rises again.
- R9: Dropping `refresh_grant` in the middle of a cycle does not shorten or abort that cycle's strobe phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| refresh_grant | input | 1 | Access sequencer hands the DRAM bus to the block |
| refresh_req | output | 1 | Block needs the bus for a refresh cycle |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| ready | output | 1 | DRAM is initialised and usable |
| overflow_err | output | 1 | Sticky: the owed-refresh backlog overflowed |

## Verification
The situation hardest to reach is starvation. It needs the grant held back for longer than the whole stale window, while the backlog overflows part-way through. Only after that does `ready` collapse and the initialisation burst restart.

The bench gets there in a directed phase. It first waits for a quiet point with nothing owed. It then withholds the grant, predicts the tick on which the overflow flag must appear and the edge on which `ready` must drop, and finally releases the grant and counts the re-initialisation cycles.

Random grant latencies and mid-cycle grant drops, drawn from a fixed seed, cover the handshake and strobe timing around all of this.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECH,
        ST_RELEASE
    } ref_state_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
    parameter int unsigned INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = $clog2(INTERVAL);

    logic [TW-1:0] cnt;

    assign tick = run && (cnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: owed refreshes are spaced, never back to back
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
    parameter int unsigned PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic owe,
    input  logic paid,
    output logic owed,
    output logic overflow
);
    localparam int unsigned PW = $clog2(PEND_MAX + 1);

    logic [PW-1:0] pend;

    assign owed = (pend != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            overflow <= 1'b0;
        end else if (clear) begin
            pend <= '0;
        end else begin
            unique case ({owe, paid})
                2'b10: begin
                    if (pend == PW'(PEND_MAX)) overflow <= 1'b1;
                    else                       pend <= pend + 1'b1;
                end
                2'b01: if (pend != '0) pend <= pend - 1'b1;
                default: ;
            endcase
        end
    end

    // R7: the backlog never holds more than its depth
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(PEND_MAX));

    // R7: one more owed refresh at full depth raises the flag
    a_r7_flag_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (owe && !paid && !clear && pend == PW'(PEND_MAX)) |=> overflow);

    // R7: the flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned PWRUP_CYC    = 20000,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned CAS_LEAD_CYC = 1,
    parameter int unsigned RAS_LOW_CYC  = 6,
    parameter int unsigned RAS_PRE_CYC  = 4,
    parameter int unsigned STALE_LIMIT  = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic owed,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic paid,
    output logic reinit
);
    localparam int unsigned PHASE_MAX = imax(imax(PWRUP_CYC, CAS_LEAD_CYC),
                                             imax(RAS_LOW_CYC, RAS_PRE_CYC));
    localparam int unsigned CW = $clog2(PHASE_MAX + 1);
    localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
    localparam int unsigned SW = $clog2(STALE_LIMIT + 1);

    ref_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] init_left;
    logic [SW-1:0] stale;
    logic          last, need, stale_hit, done;

    // phase length of the timed states
    always_comb begin
        unique case (state)
            ST_PWRUP:    last = (cnt == CW'(PWRUP_CYC - 1));
            ST_CAS_LEAD: last = (cnt == CW'(CAS_LEAD_CYC - 1));
            ST_RAS_LOW:  last = (cnt == CW'(RAS_LOW_CYC - 1));
            ST_PRECH:    last = (cnt == CW'(RAS_PRE_CYC - 1));
            default:     last = 1'b0;
        endcase
    end

    assign need      = (init_left != '0) || owed;
    assign stale_hit = (stale >= SW'(STALE_LIMIT));
    assign ready     = (init_left == '0);
    assign done      = (state == ST_RAS_LOW) && last;
    assign paid      = done && ready;
    assign reinit    = (state == ST_IDLE) && stale_hit;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWRUP:    if (last) nxt = ST_IDLE;
            ST_IDLE:     if (!stale_hit && need && grant) nxt = ST_CAS_LEAD;
            ST_CAS_LEAD: if (last) nxt = ST_RAS_LOW;
            ST_RAS_LOW:  if (last) nxt = ST_PRECH;
            ST_PRECH:    if (last) nxt = ST_RELEASE;
            ST_RELEASE:  if (!grant) nxt = ST_IDLE;
            default:     nxt = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_PWRUP;
            cnt       <= '0;
            init_left <= IW'(INIT_CYCLES);
            stale     <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == ST_IDLE || state == ST_RELEASE) cnt <= '0;
            else                                                         cnt <= cnt + 1'b1;
            if (reinit)                        init_left <= IW'(INIT_CYCLES);
            else if (done && init_left != '0)  init_left <= init_left - 1'b1;
            if (reinit || !ready || done)      stale <= '0;
            else if (!stale_hit)               stale <= stale + 1'b1;
        end
    end

    // strobe and handshake outputs
    always_comb begin
        unique case (state)
            ST_CAS_LEAD: begin ras_n = 1'b1; cas_n = 1'b0; req = 1'b1; end
            ST_RAS_LOW:  begin ras_n = 1'b0; cas_n = 1'b0; req = 1'b1; end
            ST_PRECH:    begin ras_n = 1'b1; cas_n = 1'b1; req = 1'b1; end
            ST_IDLE:     begin ras_n = 1'b1; cas_n = 1'b1; req = need; end
            default:     begin ras_n = 1'b1; cas_n = 1'b1; req = 1'b0; end
        endcase
    end

    // R1: silent during the power-up pause
    a_r1_quiet_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRUP) |-> (ras_n && cas_n && !req));

    // R3: CAS already low in the cycle before RAS falls
    a_r3_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R3: RAS never low on its own
    a_r3_no_lone_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5: a cycle starts only under grant
    a_r5_granted_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(grant));

    // R2: ready only rises as an init cycle ends its RAS-low phase
    a_r2_ready_from_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state == ST_RAS_LOW));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned PWRUP_CYC    = 20000,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned CAS_LEAD_CYC = 1,
    parameter int unsigned RAS_LOW_CYC  = 6,
    parameter int unsigned RAS_PRE_CYC  = 4,
    parameter int unsigned REF_INTERVAL = 1562,
    parameter int unsigned PEND_MAX     = 8,
    parameter int unsigned STALE_LIMIT  = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_grant,
    output logic refresh_req,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic overflow_err
);
    logic tick, owed, paid, reinit;

    dram_ref_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ready),
        .tick (tick)
    );

    dram_ref_backlog #(.PEND_MAX(PEND_MAX)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (reinit),
        .owe     (tick),
        .paid    (paid),
        .owed    (owed),
        .overflow(overflow_err)
    );

    dram_ref_seq #(
        .PWRUP_CYC   (PWRUP_CYC),
        .INIT_CYCLES (INIT_CYCLES),
        .CAS_LEAD_CYC(CAS_LEAD_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .RAS_PRE_CYC (RAS_PRE_CYC),
        .STALE_LIMIT (STALE_LIMIT)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (refresh_grant),
        .owed  (owed),
        .req   (refresh_req),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .ready (ready),
        .paid  (paid),
        .reinit(reinit)
    );

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PWRUP_T    = 50;
    localparam int INIT_T     = 8;
    localparam int LEAD_T     = 1;
    localparam int LOW_T      = 3;
    localparam int PRE_T      = 2;
    localparam int IVL_T      = 40;
    localparam int DEPTH_T    = 8;
    localparam int STALE_T    = 600;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_grant = 1'b0;
    logic refresh_req, ras_n, cas_n, ready, overflow_err;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench state
    int  cyc = 0;
    int  e_ready = 0;
    int  paid_cnt = 0;
    int  init_rises = 0;
    int  last_done = 0;
    int  rise_cyc = -1000;
    int  low_len = 0;
    int  hi_len = 1000;
    int  lead_len = 0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, prev_req = 1'b0, prev_ready = 1'b0, prev_grant = 1'b0;
    bit  grant_en = 1'b1;
    bit  drop_mid = 1'b0;
    bit  dropped = 1'b0;
    int  dly = 0;
    int  seed_dummy;

    dram_refresh_sched #(
        .PWRUP_CYC(PWRUP_T), .INIT_CYCLES(INIT_T), .CAS_LEAD_CYC(LEAD_T),
        .RAS_LOW_CYC(LOW_T), .RAS_PRE_CYC(PRE_T), .REF_INTERVAL(IVL_T),
        .PEND_MAX(DEPTH_T), .STALE_LIMIT(STALE_T)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .refresh_grant(refresh_grant),
        .refresh_req(refresh_req), .ras_n(ras_n), .cas_n(cas_n),
        .ready(ready), .overflow_err(overflow_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    function automatic int ticks_at(input int n);
        return (n > e_ready) ? (n - e_ready) / IVL_T : 0;
    endfunction

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // grant responder: drives just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!grant_en) begin
                refresh_grant = 1'b0;
            end else if (refresh_grant && drop_mid && !ras_n) begin
                refresh_grant = 1'b0;
                drop_mid = 1'b0;
                dropped = 1'b1;
            end else if (!refresh_grant && refresh_req) begin
                if (dly == 0) refresh_grant = 1'b1;
                else dly--;
            end else if (refresh_grant && !refresh_req) begin
                refresh_grant = 1'b0;
                dly = $urandom_range(0, 3);
            end
        end
    end

    // strobe monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cas && !cas_n) begin
                check(prev_grant, "R5 grant at CAS fall", prev_grant, 1);
                lead_len = 0;
            end
            if (!cas_n && ras_n) lead_len++;
            if (prev_ras && !ras_n) begin
                check(!cas_n && lead_len == LEAD_T, "R3 CAS lead", lead_len, LEAD_T);
                check(hi_len >= PRE_T, "R4 precharge", hi_len, PRE_T);
                low_len = 0;
            end
            if (!ras_n) begin
                low_len++;
                if (cas_n) check(1'b0, "R3 RAS low with CAS high", 1, 0);
            end else begin
                hi_len++;
            end
            if (!prev_ras && ras_n) begin
                if (dropped) check(low_len == LOW_T, "R9 RAS low after grant drop", low_len, LOW_T);
                else         check(low_len == LOW_T, "R4 RAS low width", low_len, LOW_T);
                dropped = 1'b0;
                check(cas_n, "R3 strobes rise together", cas_n, 1);
                check(refresh_req, "R5 req held in precharge", refresh_req, 1);
                hi_len = 1;
                rise_cyc = cyc;
                last_done = cyc;
                if (prev_ready) begin
                    paid_cnt++;
                end else begin
                    init_rises++;
                    check(ready == (init_rises == INIT_T), "R2 ready after init burst",
                          ready, (init_rises == INIT_T));
                end
            end
            if (prev_req && !refresh_req) begin
                check(ras_n && cas_n && (cyc - rise_cyc == PRE_T), "R5 req release",
                      cyc - rise_cyc, PRE_T);
            end
            if (!prev_ready && ready) begin
                e_ready = cyc;
                paid_cnt = 0;
            end
            if (prev_ready && !ready) init_rises = 0;
            prev_ras = ras_n; prev_cas = cas_n; prev_req = refresh_req;
            prev_ready = ready; prev_grant = refresh_grant;
        end
    end

    task automatic wait_quiet();
        int qn = 0;
        while (qn < 2) begin
            @(negedge clk); #1;
            if (!refresh_req && !refresh_grant) qn++;
            else qn = 0;
        end
    endtask

    task automatic check_paid();
        wait_quiet();
        check(paid_cnt == ticks_at(cyc), "R6 refreshes match intervals", paid_cnt, ticks_at(cyc));
    endtask

    initial begin
        seed_dummy = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        check(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        check(!refresh_req && !ready, "R2 idle outputs in reset", {refresh_req, ready}, 0);
        check(!overflow_err, "R7 no error in reset", overflow_err, 0);
        rst_n = 1'b1;

        while (cyc < PWRUP_T - 1) @(negedge clk);
        #1;
        check(!refresh_req && ras_n && cas_n, "R1 quiet during pause", refresh_req, 0);
        @(negedge clk); #1;
        check(refresh_req, "R1 request after pause", refresh_req, 1);

        while (!ready) begin @(negedge clk); #1; end
        check(init_rises == INIT_T, "R2 init cycle count", init_rises, INIT_T);
        check_paid();

        // random grant latency, withholding and mid-cycle drops
        for (int it = 0; it < 30; it++) begin
            int hold = $urandom_range(0, 3 * IVL_T);
            drop_mid = ($urandom_range(0, 3) == 0);
            grant_en = 1'b0;
            repeat (hold) @(negedge clk);
            grant_en = 1'b1;
            check_paid();
        end
        check(!overflow_err, "R7 no overflow within depth", overflow_err, 0);

        // directed starvation: overflow then re-initialisation
        begin
            int q, c, tq;
            wait_quiet();
            grant_en = 1'b0;
            q = cyc;
            c = last_done;
            tq = ticks_at(q);
            while (cyc < c + STALE_T + 2) begin
                @(negedge clk); #1;
                if (cyc == c + STALE_T - 1)
                    check(ready, "R8 ready before stale limit", ready, 1);
                if (ready && cyc > e_ready && ((cyc - e_ready) % IVL_T) == 0)
                    check(overflow_err == ((ticks_at(cyc) - tq) > DEPTH_T),
                          "R7 overflow on tick", overflow_err, (ticks_at(cyc) - tq) > DEPTH_T);
            end
            check(!ready, "R8 ready drops after stale limit", ready, 0);
            grant_en = 1'b1;
            while (!ready) begin @(negedge clk); #1; end
            check(init_rises == INIT_T, "R8 re-init burst length", init_rises, INIT_T);
            check(overflow_err, "R7 overflow sticky", overflow_err, 1);
            repeat (3 * IVL_T) @(negedge clk);
            check_paid();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule